// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and works out from them which error state the node is in. A protocol engine upstream does the bit-level work and reports each outcome to this block as a single-cycle pulse. The pulses are:

- a receive error, with a severity qualifier;
- a transmit error, with a severity qualifier;
- a clean reception;
- a clean transmission;
- a detected run of recessive bits, used to leave bus-off.

A 3-bit code that travels with each error pulse names the kind of fault. The block exports the receive count, the low byte of the 9-bit transmit count, three state flags and a last-error-code field that software can also load.

The rules for the two counters differ. A clean reception brings a high receive count straight down to a fixed resume value. The transmit count can pass 255. When it does, the node goes bus-off. It stays there, with both counters frozen, until enough recessive-sequence pulses have arrived.

Top module: `can_fault_conf`

## Requirements
- R1: A receive error raises the receive count by 8 when its severity input is high and by 1 otherwise, clamping at 255.
- R2: A clean reception with no receive error in the same cycle lowers the receive count by 1 and never goes below 0. If the count was above 128, it is loaded with 120 instead.
- R3: A transmit error raises a 9-bit transmit count by 8 (severe) or 1 (minor). A clean transmission lowers it by 1, stopping at 0. The transmit output shows the low 8 bits of the count.
- R4: When an error pulse and a success pulse for the same counter arrive in one cycle, only the error is applied.
- R5: The warning output is high whenever either count is 96 or more.
- R6: The passive output is high whenever either count is above 127.
- R7: Bus-off is set on the clock edge where the transmit count goes past 255. It stays set, and both counts hold their values while it is set.
- R8: While bus-off is set, the 128th recessive-sequence pulse clears both counts and drops bus-off on the same edge. Pulses that arrive outside bus-off do not count toward this total.
- R9: Any error pulse loads the last-error-code field with the input code. The codes are: 0 none, 1 stuff, 2 form, 3 acknowledgment, 4 bit-recessive, 5 bit-dominant, 6 CRC. An error takes precedence over a success in the same cycle.
- R10: A clean reception or transmission with no error in the same cycle clears the last-error-code field to 0.
- R11: A software write of value 7 loads the field with 7 if no bus event occurs in that cycle. A write of any other value is ignored. A bus event in the same cycle overrides the write.
- R12: After reset, both counts, all flags and the last-error-code field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| rx_err_i | input | 1 | Receive error pulse |
| rx_sev_i | input | 1 | Severity of the receive error (1 = step of 8) |
| tx_err_i | input | 1 | Transmit error pulse |
| tx_sev_i | input | 1 | Severity of the transmit error (1 = step of 8) |
| rx_ok_i | input | 1 | Clean reception pulse |
| tx_ok_i | input | 1 | Clean transmission pulse |
| recess_i | input | 1 | Recessive-sequence detect pulse |
| err_code_i | input | 3 | Fault code accompanying an error pulse |
| lec_wr_i | input | 1 | Software write strobe for the code field |
| lec_wdata_i | input | 3 | Software write value |
| rec_o | output | 8 | Receive error count |
| tec_o | output | 8 | Low 8 bits of transmit error count |
| warn_o | output | 1 | Warning flag |
| passive_o | output | 1 | Error-passive flag |
| busoff_o | output | 1 | Bus-off state |
| lec_o | output | 3 | Last error code |

## Verification
The hardest state to reach from the ports is bus-off entered with a transmit count other than exactly 256, followed by a full recovery. The stimulus uses 31 severe errors and 4 minor ones to bring the transmit count to 252, then a severe error takes it to 260. This leaves the exported low byte at 4 while bus-off is set. Error pulses are then applied to show the counts are frozen. Next come 127 recessive pulses, after which bus-off must still be set, and then the 128th pulse, which must clear everything. Before any of this, 200 recessive pulses are sent while the node is not bus-off, to show they are not carried over into the recovery count.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int CNT_W    = 8;
  localparam int TEC_W    = CNT_W + 1;
  localparam int SEV_STEP = 8;
  localparam int WARN_LVL = 96;
  localparam int PASS_LVL = 127;
  localparam int REC_HI   = 128;
  localparam int REC_RES  = 120;
  localparam int RECOV_N  = 128;

  typedef enum logic [2:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BREC  = 3'd4,
    LEC_BDOM  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_SW    = 3'd7
  } lec_e;
endpackage

// File: rtl/fc_rec_cnt.sv
module fc_rec_cnt #(
  parameter int W       = 8,
  parameter int STEP    = 8,
  parameter int HI      = 128,
  parameter int RESUME  = 120
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         err_i,
  input  logic         sev_i,
  input  logic         ok_i,
  input  logic         freeze_i,
  input  logic         clr_i,
  output logic [W-1:0] rec_o
);
  localparam logic [W:0]   MAXV   = (W+1)'((1 << W) - 1);
  localparam logic [W-1:0] HI_V   = W'(HI);
  localparam logic [W-1:0] RES_V  = W'(RESUME);

  logic [W-1:0] rec_q, rec_d;
  logic [W:0]   sum;
  logic         en;

  always_comb begin
    sum = {1'b0, rec_q} + (sev_i ? (W+1)'(STEP) : (W+1)'(1));
    en  = clr_i | (~freeze_i & (err_i | ok_i));
    if (clr_i)                 rec_d = '0;
    else if (err_i)            rec_d = (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
    else if (rec_q > HI_V)     rec_d = RES_V;
    else if (rec_q != '0)      rec_d = rec_q - W'(1);
    else                       rec_d = rec_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  rec_q <= '0;
    else if (en)   rec_q <= rec_d;
  end

  assign rec_o = rec_q;

  a_r1_saturate: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (err_i && !freeze_i && !clr_i && rec_q == MAXV[W-1:0]) |=> rec_q == MAXV[W-1:0]);
  a_r2_resume: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ok_i && !err_i && !freeze_i && !clr_i && rec_q > HI_V) |=> rec_q == RES_V);
  a_r4_err_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (err_i && ok_i && !freeze_i && !clr_i && rec_q < 8'd200) |=> rec_q > $past(rec_q));
endmodule

// File: rtl/fc_tec_cnt.sv
module fc_tec_cnt #(
  parameter int CW   = 8,
  parameter int STEP = 8
) (
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        err_i,
  input  logic        sev_i,
  input  logic        ok_i,
  input  logic        freeze_i,
  input  logic        clr_i,
  output logic [CW:0] tec_o,
  output logic        ovf_o
);
  localparam logic [CW:0] LIMIT = (CW+1)'((1 << CW) - 1);

  logic [CW:0] tec_q, tec_d, sum;
  logic        en;

  always_comb begin
    sum   = tec_q + (sev_i ? (CW+1)'(STEP) : (CW+1)'(1));
    en    = clr_i | (~freeze_i & (err_i | ok_i));
    ovf_o = ~clr_i & ~freeze_i & err_i & (sum > LIMIT);
    if (clr_i)               tec_d = '0;
    else if (err_i)          tec_d = sum;
    else if (tec_q != '0)    tec_d = tec_q - (CW+1)'(1);
    else                     tec_d = tec_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) tec_q <= '0;
    else if (en)  tec_q <= tec_d;
  end

  assign tec_o = tec_q;

  a_r3_floor: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ok_i && !err_i && !freeze_i && !clr_i && tec_q == '0) |=> tec_q == '0);
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (err_i && !sev_i && !freeze_i && !clr_i) |=> tec_q == $past(tec_q) + (CW+1)'(1));
endmodule

// File: rtl/fc_boff_ctl.sv
module fc_boff_ctl #(
  parameter int RECOV = 128
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ovf_i,
  input  logic recess_i,
  output logic busoff_o,
  output logic clr_o
);
  localparam int RC_W = $clog2(RECOV);
  localparam logic [RC_W-1:0] LAST = RC_W'(RECOV - 1);

  logic            boff_q, boff_d;
  logic [RC_W-1:0] rc_q, rc_d;

  always_comb begin
    clr_o  = boff_q & recess_i & (rc_q == LAST);
    boff_d = boff_q;
    if (ovf_i)      boff_d = 1'b1;
    else if (clr_o) boff_d = 1'b0;
    rc_d = rc_q;
    if (!boff_q || clr_o) rc_d = '0;
    else if (recess_i)    rc_d = rc_q + RC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      boff_q <= 1'b0;
      rc_q   <= '0;
    end else begin
      boff_q <= boff_d;
      rc_q   <= rc_d;
    end
  end

  assign busoff_o = boff_q;

  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ovf_i |=> boff_q);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (boff_q && !recess_i) |=> boff_q);
  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !boff_q |=> rc_q == '0);
endmodule

// File: rtl/fc_lec_reg.sv
module fc_lec_reg
  import can_fc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       err_i,
  input  logic       ok_i,
  input  logic [2:0] code_i,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  output logic [2:0] lec_o
);
  lec_e lec_q, lec_d;
  logic en;

  always_comb begin
    en    = err_i | ok_i | (wr_i & (wdata_i == LEC_SW));
    lec_d = lec_q;
    if (err_i)     lec_d = lec_e'(code_i);
    else if (ok_i) lec_d = LEC_NONE;
    else           lec_d = LEC_SW;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) lec_q <= LEC_NONE;
    else if (en)  lec_q <= lec_d;
  end

  assign lec_o = lec_q;

  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_i |=> lec_o == $past(code_i));
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ok_i && !err_i) |=> lec_o == 3'd0);
  a_r11_ignore: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_i && wdata_i != 3'd7 && !err_i && !ok_i) |=> $stable(lec_o));
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       rx_err_i,
  input  logic       rx_sev_i,
  input  logic       tx_err_i,
  input  logic       tx_sev_i,
  input  logic       rx_ok_i,
  input  logic       tx_ok_i,
  input  logic       recess_i,
  input  logic [2:0] err_code_i,
  input  logic       lec_wr_i,
  input  logic [2:0] lec_wdata_i,
  output logic [7:0] rec_o,
  output logic [7:0] tec_o,
  output logic       warn_o,
  output logic       passive_o,
  output logic       busoff_o,
  output logic [2:0] lec_o
);
  logic [1:0]       rsync_q;
  logic             rst_n;
  logic [CNT_W-1:0] rec;
  logic [TEC_W-1:0] tec;
  logic             ovf, clr, boff;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rsync_q <= 2'b00;
    else          rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  fc_rec_cnt #(.W(CNT_W), .STEP(SEV_STEP), .HI(REC_HI), .RESUME(REC_RES)) u_rec (
    .clk_i(clk_i), .rst_n_i(rst_n), .err_i(rx_err_i), .sev_i(rx_sev_i),
    .ok_i(rx_ok_i), .freeze_i(boff), .clr_i(clr), .rec_o(rec));

  fc_tec_cnt #(.CW(CNT_W), .STEP(SEV_STEP)) u_tec (
    .clk_i(clk_i), .rst_n_i(rst_n), .err_i(tx_err_i), .sev_i(tx_sev_i),
    .ok_i(tx_ok_i), .freeze_i(boff), .clr_i(clr), .tec_o(tec), .ovf_o(ovf));

  fc_boff_ctl #(.RECOV(RECOV_N)) u_boff (
    .clk_i(clk_i), .rst_n_i(rst_n), .ovf_i(ovf), .recess_i(recess_i),
    .busoff_o(boff), .clr_o(clr));

  fc_lec_reg u_lec (
    .clk_i(clk_i), .rst_n_i(rst_n), .err_i(rx_err_i | tx_err_i),
    .ok_i(rx_ok_i | tx_ok_i), .code_i(err_code_i), .wr_i(lec_wr_i),
    .wdata_i(lec_wdata_i), .lec_o(lec_o));

  assign rec_o     = rec;
  assign tec_o     = tec[CNT_W-1:0];
  assign warn_o    = (rec >= CNT_W'(WARN_LVL)) | (tec >= TEC_W'(WARN_LVL));
  assign passive_o = (rec >  CNT_W'(PASS_LVL)) | (tec >  TEC_W'(PASS_LVL));
  assign busoff_o  = boff;

  always_comb begin
    if (rst_n) a_r6_passive_warn: assert (!passive_o || warn_o);
  end

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_n)
    (boff && !clr) |=> ($stable(rec_o) && $stable(tec_o)));
  a_r8_recover: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr |=> (!busoff_o && rec_o == 8'd0 && tec_o == 8'd0));
endmodule

// File: tb/can_fault_conf_tb_top.sv
`timescale 1ns/1ps
module can_fault_conf_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic rxe, rxs, txe, txs, rxo, txo, rcs, wr;
  logic [2:0] code, wd;
  logic [7:0] rec, tec;
  logic warn, passive, boff;
  logic [2:0] lec;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_fault_conf dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .rx_err_i(rxe), .rx_sev_i(rxs),
    .tx_err_i(txe), .tx_sev_i(txs), .rx_ok_i(rxo), .tx_ok_i(txo),
    .recess_i(rcs), .err_code_i(code), .lec_wr_i(wr), .lec_wdata_i(wd),
    .rec_o(rec), .tec_o(tec), .warn_o(warn), .passive_o(passive),
    .busoff_o(boff), .lec_o(lec));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    rxe = 0; rxs = 0; txe = 0; txs = 0; rxo = 0; txo = 0; rcs = 0;
    wr = 0; code = 3'd0; wd = 3'd0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 rec", rec, 0);
    chk("R12 tec", tec, 0);
    chk("R12 flags", {warn, passive, boff}, 0);
    chk("R12 lec", lec, 0);
  endtask

  task automatic t_rx_count();
    do_reset();
    rxe = 1; tick();
    chk("R1 minor", rec, 1);
    rxe = 1; rxs = 1; tick();
    chk("R1 severe", rec, 9);
    for (int i = 0; i < 10; i++) begin rxe = 1; rxs = 1; tick(); end
    chk("R1 89", rec, 89);
    chk("R5 below 96", warn, 0);
    rxe = 1; rxs = 1; tick();
    chk("R5 at 97", warn, 1);
    chk("R6 at 97", passive, 0);
    for (int i = 0; i < 4; i++) begin rxe = 1; rxs = 1; tick(); end
    chk("R1 129", rec, 129);
    chk("R6 at 129", passive, 1);
    for (int i = 0; i < 20; i++) begin rxe = 1; rxs = 1; tick(); end
    chk("R1 clamp 255", rec, 255);
  endtask

  task automatic t_rx_ok();
    rxo = 1; tick();
    chk("R2 255 to 120", rec, 120);
    rxo = 1; tick();
    chk("R2 dec", rec, 119);
    rxe = 1; rxs = 1; tick();
    chk("R6 at 127", passive, 0);
    chk("R5 at 127", warn, 1);
    rxe = 1; tick();
    chk("R6 at 128", passive, 1);
    rxo = 1; tick();
    chk("R2 128 decrements", rec, 127);
    do_reset();
    rxo = 1; tick();
    chk("R2 floor", rec, 0);
  endtask

  task automatic t_prec();
    do_reset();
    rxe = 1; rxo = 1; code = 3'd3; tick();
    chk("R4 rx", rec, 1);
    chk("R9 err over ok", lec, 3);
    txe = 1; txs = 1; txo = 1; code = 3'd5; tick();
    chk("R4 tx", tec, 8);
    chk("R9 bit-dominant", lec, 5);
  endtask

  task automatic t_tx();
    do_reset();
    txe = 1; tick();
    chk("R3 minor", tec, 1);
    txe = 1; txs = 1; tick();
    chk("R3 severe", tec, 9);
    txo = 1; tick();
    chk("R3 dec", tec, 8);
    for (int i = 0; i < 8; i++) begin txo = 1; tick(); end
    chk("R3 zero", tec, 0);
    txo = 1; tick();
    chk("R3 floor", tec, 0);
  endtask

  task automatic t_busoff();
    do_reset();
    for (int i = 0; i < 200; i++) begin rcs = 1; tick(); end
    chk("R8 no busoff", boff, 0);
    for (int i = 0; i < 5; i++) begin rxe = 1; tick(); end
    for (int i = 0; i < 31; i++) begin txe = 1; txs = 1; tick(); end
    for (int i = 0; i < 4; i++) begin txe = 1; tick(); end
    chk("R3 252", tec, 252);
    chk("R7 not yet", boff, 0);
    chk("R6 tx passive", passive, 1);
    txe = 1; txs = 1; tick();
    chk("R7 entered", boff, 1);
    chk("R3 low byte", tec, 4);
    chk("R6 in busoff", passive, 1);
    rxe = 1; txe = 1; txs = 1; tick();
    chk("R7 rec frozen", rec, 5);
    chk("R7 tec frozen", tec, 4);
    rxo = 1; txo = 1; tick();
    chk("R7 rec frozen ok", rec, 5);
    for (int i = 0; i < 127; i++) begin rcs = 1; tick(); end
    chk("R8 127 pulses", boff, 1);
    rcs = 1; tick();
    chk("R8 left", boff, 0);
    chk("R8 rec clr", rec, 0);
    chk("R8 tec clr", tec, 0);
    chk("R8 flags", {warn, passive}, 0);
  endtask

  task automatic t_lec();
    do_reset();
    rxe = 1; code = 3'd1; tick();
    chk("R9 stuff", lec, 1);
    txe = 1; code = 3'd6; tick();
    chk("R9 crc", lec, 6);
    wr = 1; wd = 3'd7; tick();
    chk("R11 sw 7", lec, 7);
    wr = 1; wd = 3'd5; tick();
    chk("R11 ignored", lec, 7);
    rxo = 1; tick();
    chk("R10 clear rx", lec, 0);
    wr = 1; wd = 3'd7; tick();
    chk("R11 sw 7 again", lec, 7);
    rxe = 1; code = 3'd2; wr = 1; wd = 3'd7; tick();
    chk("R11 hw wins", lec, 2);
    txo = 1; tick();
    chk("R10 clear tx", lec, 0);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_rx_count();
    t_rx_ok();
    t_prec();
    t_tx();
    t_busoff();
    t_lec();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule